// File: doc/BRIEF.md
# Dual Data Address Generator

This block forms memory addresses for two address generators that work side by side. Each generator keeps eight slots, and each slot holds four registers: an index, a step (modify), a window length and a window base. A request on a generator's port names an index register and an offset. The offset is either one of that generator's step registers or a signed immediate. One control bit sets the mode. In post-step mode the block issues the current index as the address and moves the index forward. In pre-step mode the block issues the index plus the offset and leaves the index alone.

When a slot's length register is non-zero, the index update is circular: it stays inside the window that starts at the base and spans the length. When the length is zero, the update is plain modulo-2^32 arithmetic. Each port also accepts two operations that change the index without issuing an address: a standalone step by an immediate, and a step followed by a reversal of the bit order. One write port and one combinational read port reach every register of both generators. The generator is picked by the top bit of a 4-bit register number.

Top module: `dual_addr_gen`

## Requirements
- R1: After reset every index, step, length and base register of both generators reads zero, and acc_valid and req_err are low.
- R2: A write with kind code index=0, step=1, length=2, base=3 and register number {generator bit, slot[2:0]} is visible on rd_data, which is combinational, from the cycle after the write.
- R3: Writing a base register also loads the index register of the same slot with the written value.
- R4: An address request (req_op=0) with req_post=1 gives acc_valid=1 and acc_addr equal to the old index one cycle later. The index then holds the updated value.
- R5: An address request with req_post=0 gives acc_addr = index + offset (modulo 2^32, never wrapped to the window) one cycle later, and leaves the index unchanged.
- R6: The offset of an address request is the signed req_imm when req_use_imm=1. Otherwise it is the step register named by req_mnum, and req_mnum is ignored when req_use_imm=1.
- R7: With a non-zero length L and base B, an index update computes s = index + offset. If s >= B+L the result is s-L, if s < B the result is s+L, and otherwise it is s.
- R8: With length zero, an index update is index + offset modulo 2^32.
- R9: A step operation (req_op=1) writes the R7/R8 update of index + req_imm into the index and gives no acc_valid.
- R10: A reverse operation (req_op=2) writes the bit-reversed 32-bit value of index + req_imm into the index and gives no acc_valid.
- R11: Port g accepts only register numbers whose top bit equals g. This applies to the index always, and to the step register when it is used. A request that breaks this rule, or that has req_op=3, raises req_err for one cycle and changes no register.
- R12: Both ports serve one request each in the same cycle, independently of each other.
- R13: When a register write reaches an index register that a request updates in the same cycle, the written value is the one kept. This includes the index loaded by a base write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request strobe, one per generator port |
| req_op | input | 2x2 | Operation: 0 address, 1 step, 2 reverse, 3 invalid |
| req_post | input | 2 | 1 = post-step with update, 0 = pre-step without update |
| req_use_imm | input | 2 | Offset source: 1 immediate, 0 step register |
| req_inum | input | 2x4 | Index register number |
| req_mnum | input | 2x4 | Step register number |
| req_imm | input | 2x32 | Signed immediate |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind of the write |
| wr_num | input | 4 | Register number of the write |
| wr_data | input | 32 | Write data |
| rd_kind | input | 2 | Register kind to read |
| rd_num | input | 4 | Register number to read |
| rd_data | output | 32 | Read data |
| acc_valid | output | 2 | Address issued, per port |
| acc_addr | output | 2x32 | Issued address, per port |
| req_err | output | 2 | Request rejected, per port |

## Verification
A post-step sweep with a positive step walks the index up to the window end and shows that it folds back to the base. A negative step then drops below the base, which separates the upper wrap check from the lower one. Pre-step and immediate requests on the same slot show that the address and the write-back come from the right offset and the right mode. A length-zero slot placed near 2^32 shows that the update is linear modulo 2^32 and not windowed. Requests that cross generators, the invalid operation code, simultaneous traffic on both ports, and writes that collide with an update each isolate one rule: rejection, independence of the ports, and which value wins.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [1:0] {
        OP_ACCESS = 2'd0,
        OP_MODIFY = 2'd1,
        OP_BITREV = 2'd2,
        OP_RSVD   = 2'd3
    } dag_op_e;

    typedef enum logic [1:0] {
        RK_INDEX  = 2'd0,
        RK_MODIFY = 2'd1,
        RK_LENGTH = 2'd2,
        RK_BASE   = 2'd3
    } dag_kind_e;

endpackage

// File: rtl/dag_wrap.sv
module dag_wrap #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] off,
    input  logic [W-1:0] len,
    input  logic [W-1:0] base,
    output logic [W-1:0] lin_sum,
    output logic [W-1:0] wrapped
);

    logic [W:0] limit;

    always_comb begin
        lin_sum = cur + off;
        limit   = {1'b0, base} + {1'b0, len};
        if (len == '0) begin
            wrapped = lin_sum;
        end else if ({1'b0, lin_sum} >= limit) begin
            wrapped = lin_sum - len;
        end else if (lin_sum < base) begin
            wrapped = lin_sum + len;
        end else begin
            wrapped = lin_sum;
        end
    end

endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign dout[b] = din[W-1-b];
    end

endmodule

// File: rtl/dag_bank.sv
module dag_bank
    import dag_pkg::*;
#(
    parameter int W      = 32,
    parameter int SLOTS  = 8,
    parameter int GEN_W  = 1,
    parameter int GEN_ID = 0,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int NUM_W  = GEN_W + SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_post,
    input  logic              req_use_imm,
    input  logic [NUM_W-1:0]  req_inum,
    input  logic [NUM_W-1:0]  req_mnum,
    input  logic [W-1:0]      req_imm,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [W-1:0]      wr_data,
    input  logic [1:0]        rd_kind,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [W-1:0]      rd_data,
    output logic              acc_valid,
    output logic [W-1:0]      acc_addr,
    output logic              req_err
);

    localparam logic [GEN_W-1:0] MY_GEN = GEN_W'(GEN_ID);

    typedef struct packed {
        logic [SLOTS-1:0][W-1:0] idx;
        logic [SLOTS-1:0][W-1:0] mdf;
        logic [SLOTS-1:0][W-1:0] len;
        logic [SLOTS-1:0][W-1:0] bas;
        logic                    vld;
        logic [W-1:0]            addr;
        logic                    err;
    } bank_t;

    bank_t st_d, st_q;

    dag_op_e           op;
    dag_kind_e         wkind;
    dag_kind_e         rkind;
    logic [SLOT_W-1:0] i_slot;
    logic [SLOT_W-1:0] m_slot;
    logic              i_gen_ok;
    logic              m_gen_ok;
    logic              accept;
    logic [W-1:0]      cur_i;
    logic [W-1:0]      cur_l;
    logic [W-1:0]      cur_b;
    logic [W-1:0]      offset;
    logic [W-1:0]      lin_sum;
    logic [W-1:0]      wrp;
    logic [W-1:0]      rev;

    assign op       = dag_op_e'(req_op);
    assign wkind    = dag_kind_e'(wr_kind);
    assign rkind    = dag_kind_e'(rd_kind);
    assign i_slot   = req_inum[SLOT_W-1:0];
    assign m_slot   = req_mnum[SLOT_W-1:0];
    assign i_gen_ok = (req_inum[NUM_W-1:SLOT_W] == MY_GEN);
    assign m_gen_ok = (req_mnum[NUM_W-1:SLOT_W] == MY_GEN);
    assign accept   = i_gen_ok && (op != OP_RSVD) &&
                      ((op != OP_ACCESS) || req_use_imm || m_gen_ok);

    assign cur_i  = st_q.idx[i_slot];
    assign cur_l  = st_q.len[i_slot];
    assign cur_b  = st_q.bas[i_slot];
    assign offset = ((op == OP_ACCESS) && !req_use_imm) ? st_q.mdf[m_slot] : req_imm;

    dag_wrap #(.W(W)) u_wrap (
        .cur     (cur_i),
        .off     (offset),
        .len     (cur_l),
        .base    (cur_b),
        .lin_sum (lin_sum),
        .wrapped (wrp)
    );

    dag_bitrev #(.W(W)) u_rev (
        .din  (lin_sum),
        .dout (rev)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.err  = 1'b0;
        st_d.addr = '0;
        if (req_valid) begin
            if (!accept) begin
                st_d.err = 1'b1;
            end else begin
                case (op)
                    OP_ACCESS: begin
                        st_d.vld = 1'b1;
                        if (req_post) begin
                            st_d.addr        = cur_i;
                            st_d.idx[i_slot] = wrp;
                        end else begin
                            st_d.addr = lin_sum;
                        end
                    end
                    OP_MODIFY: st_d.idx[i_slot] = wrp;
                    OP_BITREV: st_d.idx[i_slot] = rev;
                    default:   st_d.err = 1'b1;
                endcase
            end
        end
        // explicit writes are applied last so they override updates
        if (wr_en) begin
            case (wkind)
                RK_INDEX:  st_d.idx[wr_slot] = wr_data;
                RK_MODIFY: st_d.mdf[wr_slot] = wr_data;
                RK_LENGTH: st_d.len[wr_slot] = wr_data;
                RK_BASE: begin
                    st_d.bas[wr_slot] = wr_data;
                    st_d.idx[wr_slot] = wr_data;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rkind)
            RK_INDEX:  rd_data = st_q.idx[rd_slot];
            RK_MODIFY: rd_data = st_q.mdf[rd_slot];
            RK_LENGTH: rd_data = st_q.len[rd_slot];
            default:   rd_data = st_q.bas[rd_slot];
        endcase
    end

    assign acc_valid = st_q.vld;
    assign acc_addr  = st_q.addr;
    assign req_err   = st_q.err;

endmodule

// File: rtl/dual_addr_gen.sv
module dual_addr_gen #(
    parameter int W     = 32,
    parameter int SLOTS = 8,
    parameter int GENS  = 2,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int GEN_W  = $clog2(GENS),
    localparam int NUM_W  = GEN_W + SLOT_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [GENS-1:0]            req_valid,
    input  logic [GENS-1:0][1:0]       req_op,
    input  logic [GENS-1:0]            req_post,
    input  logic [GENS-1:0]            req_use_imm,
    input  logic [GENS-1:0][NUM_W-1:0] req_inum,
    input  logic [GENS-1:0][NUM_W-1:0] req_mnum,
    input  logic [GENS-1:0][W-1:0]     req_imm,
    input  logic                       wr_en,
    input  logic [1:0]                 wr_kind,
    input  logic [NUM_W-1:0]           wr_num,
    input  logic [W-1:0]               wr_data,
    input  logic [1:0]                 rd_kind,
    input  logic [NUM_W-1:0]           rd_num,
    output logic [W-1:0]               rd_data,
    output logic [GENS-1:0]            acc_valid,
    output logic [GENS-1:0][W-1:0]     acc_addr,
    output logic [GENS-1:0]            req_err
);

    logic [W-1:0] bank_rd [GENS];

    for (genvar g = 0; g < GENS; g++) begin : g_bank
        logic wr_hit;
        assign wr_hit = wr_en && (wr_num[NUM_W-1:SLOT_W] == GEN_W'(g));

        dag_bank #(
            .W      (W),
            .SLOTS  (SLOTS),
            .GEN_W  (GEN_W),
            .GEN_ID (g)
        ) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_valid   (req_valid[g]),
            .req_op      (req_op[g]),
            .req_post    (req_post[g]),
            .req_use_imm (req_use_imm[g]),
            .req_inum    (req_inum[g]),
            .req_mnum    (req_mnum[g]),
            .req_imm     (req_imm[g]),
            .wr_en       (wr_hit),
            .wr_kind     (wr_kind),
            .wr_slot     (wr_num[SLOT_W-1:0]),
            .wr_data     (wr_data),
            .rd_kind     (rd_kind),
            .rd_slot     (rd_num[SLOT_W-1:0]),
            .rd_data     (bank_rd[g]),
            .acc_valid   (acc_valid[g]),
            .acc_addr    (acc_addr[g]),
            .req_err     (req_err[g])
        );
    end

    assign rd_data = bank_rd[rd_num[NUM_W-1:SLOT_W]];

endmodule

// File: rtl/dag_checker.sv
module dag_checker #(
    parameter int W     = 32,
    parameter int SLOTS = 8,
    parameter int GENS  = 2,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int GEN_W  = $clog2(GENS),
    localparam int NUM_W  = GEN_W + SLOT_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [GENS-1:0]            req_valid,
    input logic [GENS-1:0][1:0]       req_op,
    input logic [GENS-1:0]            req_post,
    input logic [GENS-1:0]            req_use_imm,
    input logic [GENS-1:0][NUM_W-1:0] req_inum,
    input logic [GENS-1:0][NUM_W-1:0] req_mnum,
    input logic                       wr_en,
    input logic [1:0]                 rd_kind,
    input logic [NUM_W-1:0]           rd_num,
    input logic [W-1:0]               rd_data,
    input logic [GENS-1:0]            acc_valid,
    input logic [GENS-1:0][W-1:0]     acc_addr,
    input logic [GENS-1:0]            req_err
);

    for (genvar g = 0; g < GENS; g++) begin : g_chk
        localparam logic [GEN_W-1:0] GID = GEN_W'(g);
        logic good_acc;
        assign good_acc = req_valid[g] && (req_op[g] == 2'd0) &&
                          (req_inum[g][NUM_W-1:SLOT_W] == GID) &&
                          (req_use_imm[g] || (req_mnum[g][NUM_W-1:SLOT_W] == GID)) &&
                          (rd_kind == 2'd0) && (rd_num == req_inum[g]);

        AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(acc_valid[g] && req_err[g])); // R11

        AST_ADDR_ONLY_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
            acc_valid[g] |-> ($past(req_valid[g]) && ($past(req_op[g]) == 2'd0))); // R9 R10

        AST_FOREIGN_INDEX_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && (req_inum[g][NUM_W-1:SLOT_W] != GID)) |=> req_err[g]); // R11

        AST_POST_EMITS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
            (good_acc && req_post[g]) |=> (acc_valid[g] && (acc_addr[g] == $past(rd_data)))); // R4

        AST_PRE_KEEPS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
            (good_acc && !req_post[g] && !wr_en) |=>
            ((rd_kind != 2'd0) || (rd_num != $past(rd_num)) || (rd_data == $past(rd_data)))); // R5
    end

endmodule

bind dual_addr_gen dag_checker #(.W(W), .SLOTS(SLOTS), .GENS(GENS)) u_dag_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_post    (req_post),
    .req_use_imm (req_use_imm),
    .req_inum    (req_inum),
    .req_mnum    (req_mnum),
    .wr_en       (wr_en),
    .rd_kind     (rd_kind),
    .rd_num      (rd_num),
    .rd_data     (rd_data),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .req_err     (req_err)
);

// File: tb/test_dual_addr_gen.sv
`timescale 1ns/1ps
module test_dual_addr_gen;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       t_v = '0;
    logic [1:0][1:0]  t_op = '0;
    logic [1:0]       t_post = '0;
    logic [1:0]       t_ui = '0;
    logic [1:0][3:0]  t_inum = '0;
    logic [1:0][3:0]  t_mnum = '0;
    logic [1:0][31:0] t_imm = '0;
    logic             t_wen = 1'b0;
    logic [1:0]       t_wkind = '0;
    logic [3:0]       t_wnum = '0;
    logic [31:0]      t_wdata = '0;
    logic [1:0]       t_rkind = '0;
    logic [3:0]       t_rnum = '0;
    logic [31:0]      rd_data;
    logic [1:0]       acc_valid;
    logic [1:0][31:0] acc_addr;
    logic [1:0]       req_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] mreg [4][16];

    always #4 clk = ~clk;

    dual_addr_gen i_dual_addr_gen (
        .clk(clk), .rst_n(rst_n),
        .req_valid(t_v), .req_op(t_op), .req_post(t_post), .req_use_imm(t_ui),
        .req_inum(t_inum), .req_mnum(t_mnum), .req_imm(t_imm),
        .wr_en(t_wen), .wr_kind(t_wkind), .wr_num(t_wnum), .wr_data(t_wdata),
        .rd_kind(t_rkind), .rd_num(t_rnum), .rd_data(rd_data),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .req_err(req_err)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] circ(input logic [31:0] cur, input logic [31:0] off,
                                         input logic [31:0] len, input logic [31:0] base);
        logic [31:0] s;
        longint top;
        s = cur + off;
        top = longint'(base) + longint'(len);
        if (len == 0) return s;
        if (longint'(s) >= top) return s - len;
        if (s < base) return s + len;
        return s;
    endfunction

    function automatic logic [31:0] brev(input logic [31:0] x);
        logic [31:0] r;
        for (int b = 0; b < 32; b++) r[b] = x[31-b];
        return r;
    endfunction

    task automatic req(input int g, input int op, input bit post, input bit ui,
                       input int inum, input int mnum, input logic [31:0] imm);
        t_v[g] = 1'b1; t_op[g] = 2'(op); t_post[g] = post; t_ui[g] = ui;
        t_inum[g] = 4'(inum); t_mnum[g] = 4'(mnum); t_imm[g] = imm;
    endtask

    task automatic wr(input int kind, input int num, input logic [31:0] data);
        t_wen = 1'b1; t_wkind = 2'(kind); t_wnum = 4'(num); t_wdata = data;
    endtask

    task automatic rd(input int kind, input int num);
        t_rkind = 2'(kind); t_rnum = 4'(num);
    endtask

    // reference step: model from pre-edge state, then compare after the edge
    task automatic tick(input string tag);
        logic [1:0]  ev, ee;
        logic [31:0] ea [2];
        logic [31:0] nidx [16];
        logic [31:0] cur, off, lsum;
        bit ok;
        int in, mn;
        for (int k = 0; k < 16; k++) nidx[k] = mreg[0][k];
        ev = '0; ee = '0; ea[0] = '0; ea[1] = '0;
        for (int g = 0; g < 2; g++) begin
            if (t_v[g]) begin
                in = int'(t_inum[g]); mn = int'(t_mnum[g]);
                ok = (t_inum[g][3] == g[0]) && (t_op[g] != 2'd3) &&
                     (t_op[g] != 2'd0 || t_ui[g] || t_mnum[g][3] == g[0]);
                if (!ok) ee[g] = 1'b1;
                else begin
                    cur = mreg[0][in];
                    off = (t_op[g] == 2'd0 && !t_ui[g]) ? mreg[1][mn] : t_imm[g];
                    lsum = cur + off;
                    case (t_op[g])
                        2'd0: begin
                            ev[g] = 1'b1;
                            if (t_post[g]) begin
                                ea[g] = cur;
                                nidx[in] = circ(cur, off, mreg[2][in], mreg[3][in]);
                            end else ea[g] = lsum;
                        end
                        2'd1: nidx[in] = circ(cur, off, mreg[2][in], mreg[3][in]);
                        default: nidx[in] = brev(lsum);
                    endcase
                end
            end
        end
        for (int k = 0; k < 16; k++) mreg[0][k] = nidx[k];
        if (t_wen) begin
            mreg[t_wkind][t_wnum] = t_wdata;
            if (t_wkind == 2'd3) mreg[0][t_wnum] = t_wdata;
        end
        @(posedge clk);
        @(negedge clk);
        for (int g = 0; g < 2; g++) begin
            chk(tag, $sformatf("acc_valid[%0d]", g), 32'(acc_valid[g]), 32'(ev[g]));
            chk(tag, $sformatf("req_err[%0d]", g), 32'(req_err[g]), 32'(ee[g]));
            if (ev[g]) chk(tag, $sformatf("acc_addr[%0d]", g), acc_addr[g], ea[g]);
        end
        chk(tag, $sformatf("rd kind %0d num %0d", t_rkind, t_rnum), rd_data, mreg[t_rkind][t_rnum]);
        t_v = '0; t_wen = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++)
            for (int n = 0; n < 16; n++) mreg[k][n] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 16; n++) begin
                rd(k, n);
                #1;
                chk("R1", $sformatf("reset reg kind %0d num %0d", k, n), rd_data, 32'h0);
                @(negedge clk);
            end
        end
        chk("R1", "reset acc_valid", 32'(acc_valid), 32'h0);
        chk("R1", "reset req_err", 32'(req_err), 32'h0);

        // R3: base write also loads the index
        wr(3, 0, 32'h100); rd(0, 0); tick("R3");
        wr(2, 0, 32'h10);  rd(2, 0); tick("R2");
        wr(1, 0, 32'h4);   rd(1, 0); tick("R2");
        wr(1, 1, 32'hFFFF_FFF8); rd(1, 1); tick("R2");
        wr(1, 9, 32'h10);  rd(1, 9); tick("R2");
        wr(0, 9, 32'h2000); rd(0, 9); tick("R2");

        // R4 / R7: post-step sweep to the window end and back to the base
        for (int i = 0; i < 5; i++) begin
            req(0, 0, 1'b1, 1'b0, 0, 0, 32'h0); rd(0, 0); tick("R7");
        end
        // R7: negative step below the base
        req(0, 0, 1'b1, 1'b0, 0, 1, 32'h0); rd(0, 0); tick("R7");
        req(0, 0, 1'b1, 1'b0, 0, 0, 32'h0); rd(0, 0); tick("R4");
        // R5: pre-step leaves the index
        req(0, 0, 1'b0, 1'b0, 0, 0, 32'h0); rd(0, 0); tick("R5");
        req(0, 0, 1'b0, 1'b0, 0, 1, 32'h0); rd(0, 0); tick("R5");
        // R6: immediate offsets
        req(0, 0, 1'b1, 1'b1, 0, 0, 32'hFFFF_FFFD); rd(0, 0); tick("R6");
        req(0, 0, 1'b0, 1'b1, 0, 0, 32'h20); rd(0, 0); tick("R6");
        // R12: both ports together, generator 1 slot 1 is linear (R8)
        req(0, 0, 1'b1, 1'b0, 0, 0, 32'h0);
        req(1, 0, 1'b1, 1'b0, 9, 9, 32'h0); rd(0, 9); tick("R12");
        rd(0, 0); tick("R12");
        // R8: linear wrap modulo 2^32
        wr(0, 2, 32'hFFFF_FFFC); rd(0, 2); tick("R2");
        req(0, 0, 1'b1, 1'b1, 2, 0, 32'h8); rd(0, 2); tick("R8");
        // R9: standalone step on both generators
        req(0, 1, 1'b0, 1'b0, 0, 0, 32'h7);
        req(1, 1, 1'b0, 1'b0, 9, 0, 32'h100); rd(0, 0); tick("R9");
        rd(0, 9); tick("R9");
        // R10: reverse operation
        req(1, 2, 1'b0, 1'b0, 9, 0, 32'h1); rd(0, 9); tick("R10");
        req(0, 2, 1'b1, 1'b0, 3, 0, 32'h0000_0003); rd(0, 3); tick("R10");
        // R11: rejected requests change nothing
        req(0, 0, 1'b1, 1'b0, 9, 0, 32'h0); rd(0, 9); tick("R11");
        req(1, 0, 1'b1, 1'b0, 9, 2, 32'h0); rd(0, 9); tick("R11");
        req(0, 3, 1'b1, 1'b0, 0, 0, 32'h5); rd(0, 0); tick("R11");
        req(1, 1, 1'b0, 1'b0, 1, 0, 32'h5); rd(0, 1); tick("R11");
        // R6: step number ignored with immediate
        req(1, 0, 1'b1, 1'b1, 9, 2, 32'h40); rd(0, 9); tick("R6");
        // R13: write beats update
        wr(0, 0, 32'h55);
        req(0, 0, 1'b1, 1'b0, 0, 0, 32'h0); rd(0, 0); tick("R13");
        wr(3, 0, 32'h108);
        req(0, 1, 1'b0, 1'b0, 0, 0, 32'h3); rd(0, 0); tick("R13");
        req(0, 0, 1'b1, 1'b0, 0, 0, 32'h0); rd(0, 0); tick("R7");
        req(0, 0, 1'b1, 1'b0, 0, 0, 32'h0); rd(0, 0); tick("R7");
        rd(3, 0); tick("R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule